// File: doc/BRIEF.md
# Message-Signalled Interrupt Dispatcher with Pending Replay

This block converts per-vector interrupt requests into message-signalled interrupt writes. A requester presents a vector index with a valid strobe. The block reads the live capability settings: the enable bit, the granted vector count (as a log2 field), the address dwords, the 16-bit data word, the per-vector mask and whether per-vector masking is implemented. From these it forms one 64-bit address and one 32-bit data word. That message is offered on a valid/ready write-request port, one message at a time.

A request for a masked vector sends nothing and sets that vector's bit in a pending register instead. When the configuration is written while the capability is enabled, the block first discards pending bits that lie outside the granted range. It then walks the vector indices upward from zero. Every pending vector that is now unmasked has its pending bit cleared and its message sent. New requests are stalled while a message waits for the downstream side or while this walk is running.

Top module: `msi_dispatch`

## Requirements
- R1: A request accepted while enabled for an in-range vector whose mask bit is set (masking implemented) produces no message and sets `pend_vec[vector]` on the next clock edge.
- R2: Message data is `cfg_data` zero-extended to 32 bits. When the granted count N is above 1, bits [log2(N)-1:0] are replaced by the vector index. When N is 1, the data is unchanged.
- R3: With `cfg_addr64` low, `msg_addr` is `{32'h0, cfg_addr_lo}`. With it high, `msg_addr` is `{cfg_addr_hi, cfg_addr_lo}`.
- R4: With `cfg_mask_cap` low, no vector is treated as masked and no pending bit is ever set. Requests send messages whatever `cfg_mask` holds.
- R5: A `cfg_update` pulse while enabled clears every pending bit whose index is at or above the granted count N, on the next clock edge.
- R6: After a `cfg_update` pulse while enabled with masking implemented, vectors 0 up to N-1 are visited in ascending order. Each pending and unmasked vector has its pending bit cleared and its message sent. Pending vectors that are still masked stay pending.
- R7: A request accepted while enabled whose vector index is N or above sends nothing and changes no pending bit. It raises `req_err` for exactly one cycle, on the cycle after acceptance.
- R8: `req_ready` is low while a message is held on `msg_valid` or while a pending walk runs. A held message keeps `msg_addr` and `msg_data` stable until `msg_ready` takes it.
- R9: While `cfg_enable` is low, accepted requests are dropped: no message, no pending bit, no error. A `cfg_update` pulse in that state starts no walk.
- R10: A `cfg_log_vec` value above log2(VEC_MAX) is treated as log2(VEC_MAX). With the default VEC_MAX of 32, that is a granted count of 32.
- R11: After reset, `msg_valid` and `req_err` are low, `req_ready` is high and `pend_vec` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Interrupt request strobe |
| req_vector | input | VIDX_W | Requested vector index |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_err | output | 1 | One-cycle flag for an out-of-range vector |
| cfg_enable | input | 1 | Capability enable |
| cfg_log_vec | input | 3 | Log2 of the granted vector count |
| cfg_addr64 | input | 1 | 64-bit message address selected |
| cfg_addr_lo | input | 32 | Low address dword |
| cfg_addr_hi | input | 32 | High address dword |
| cfg_data | input | 16 | Message data word |
| cfg_mask_cap | input | 1 | Per-vector masking implemented |
| cfg_mask | input | VEC_MAX | Per-vector mask bits |
| cfg_update | input | 1 | One-cycle pulse: configuration was written |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Downstream takes the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| pend_vec | output | VEC_MAX | Pending bits, one per vector |

## Verification
The assertions assume that the capability inputs are quasi-static. They change only between messages and only alongside a `cfg_update` pulse. They also assume that `msg_ready` is not withdrawn in a way that matters to a held message, and that `req_vector` is stable while `req_valid` is high. The bench changes configuration only while the block is idle, raises one request at a time only when `req_ready` is high, and pulses `cfg_update` for exactly one cycle. It also holds `msg_ready` low on purpose to exercise the stall.

// File: rtl/msi_disp_pkg.sv
// Shared types and helpers for the message-signalled interrupt dispatcher.
// Assumes the granted-count field is three bits wide, as in the capability.
package msi_disp_pkg;

    localparam int LOGF_W = 3;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } msi_msg_t;

    // Clamp a requested log2 vector count to the largest the block supports.
    function automatic logic [LOGF_W-1:0] clamp_log(input logic [LOGF_W-1:0] req,
                                                    input logic [LOGF_W-1:0] lim);
        return (req > lim) ? lim : req;
    endfunction

endpackage

// File: rtl/msi_msg_fmt.sv
// Message former: builds address and data for one vector from the live
// capability values. Purely combinational.
// Assumes vec is below the granted count (1 << log_n).
module msi_msg_fmt
    import msi_disp_pkg::*;
#(
    parameter int VIDX_W = 5
) (
    input  logic [VIDX_W-1:0] vec,
    input  logic [LOGF_W-1:0] log_n,
    input  logic              addr64,
    input  logic [31:0]       addr_lo,
    input  logic [31:0]       addr_hi,
    input  logic [15:0]       data16,
    output msi_msg_t          msg
);

    logic [31:0] low_mask;

    // Merge the vector number into the low data bits and pick the address width.
    always_comb begin
        low_mask      = (32'd1 << log_n) - 32'd1;
        msg.data      = ({16'h0, data16} & ~low_mask) | (32'(vec) & low_mask);
        msg.addr      = addr64 ? {addr_hi, addr_lo} : {32'h0, addr_lo};
    end

endmodule

// File: rtl/msi_pend_reg.sv
// Pending-bit register: one bit per vector, with set, clear and range trim.
// The trim is applied before a set in the same cycle. The caller never sets a
// bit outside the kept range.
module msi_pend_reg #(
    parameter int VEC_MAX = 32,
    localparam int VIDX_W = $clog2(VEC_MAX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [VIDX_W-1:0]  set_idx,
    input  logic               clr_en,
    input  logic [VIDX_W-1:0]  clr_idx,
    input  logic               trim_en,
    input  logic [VEC_MAX-1:0] keep_mask,
    output logic [VEC_MAX-1:0] pend_q
);

    logic [VEC_MAX-1:0] pend_nxt;

    // Next pending value: trim, then clear, then set.
    always_comb begin
        pend_nxt = pend_q;
        if (trim_en) pend_nxt = pend_nxt & keep_mask;
        if (clr_en)  pend_nxt[clr_idx] = 1'b0;
        if (set_en)  pend_nxt[set_idx] = 1'b1;
    end

    // Pending storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nxt;
    end

    // R1: a parked vector shows as pending on the following cycle.
    assert_set_sticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> pend_q[$past(set_idx)]);

    // R6: a replayed vector is no longer pending afterwards.
    assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !pend_q[$past(clr_idx)]);

endmodule

// File: rtl/msi_scan_seq.sv
// Pending walk sequencer: visits vector indices upward from zero, one per
// cycle in which step_ok is high, and ends after last_idx.
// A start pulse restarts the walk. An abort stops it.
module msi_scan_seq #(
    parameter int VEC_MAX = 32,
    localparam int VIDX_W = $clog2(VEC_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              step_ok,
    input  logic [VIDX_W-1:0] last_idx,
    output logic              active,
    output logic [VIDX_W-1:0] idx
);

    // Walk state: restart, stop, or advance by one index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (abort) begin
            active <= 1'b0;
        end else if (active && step_ok) begin
            if (idx >= last_idx) active <= 1'b0;
            else                 idx    <= idx + 1'b1;
        end
    end

    // R6: the walk advances in ascending order without skipping an index.
    assert_scan_ascend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && step_ok && !start && !abort && idx < last_idx)
        |=> (active && idx == $past(idx) + 1'b1));

    // R6: every walk begins at vector zero.
    assert_scan_from_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active && idx == '0));

endmodule

// File: rtl/msi_dispatch.sv
// Message-signalled interrupt dispatcher. It accepts vector requests, parks
// masked vectors as pending bits, replays unmasked pending vectors after a
// configuration write, and offers one message at a time on a valid/ready port.
// Assumes the capability inputs change only together with a cfg_update pulse.
module msi_dispatch
    import msi_disp_pkg::*;
#(
    parameter int VEC_MAX = 32,
    localparam int VIDX_W = $clog2(VEC_MAX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VIDX_W-1:0]  req_vector,
    output logic               req_ready,
    output logic               req_err,
    input  logic               cfg_enable,
    input  logic [2:0]         cfg_log_vec,
    input  logic               cfg_addr64,
    input  logic [31:0]        cfg_addr_lo,
    input  logic [31:0]        cfg_addr_hi,
    input  logic [15:0]        cfg_data,
    input  logic               cfg_mask_cap,
    input  logic [VEC_MAX-1:0] cfg_mask,
    input  logic               cfg_update,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    output logic [VEC_MAX-1:0] pend_vec
);

    localparam logic [LOGF_W-1:0] LOG_MAX = LOGF_W'($clog2(VEC_MAX));

    logic [LOGF_W-1:0]  log_eff;
    logic [VIDX_W-1:0]  last_idx;
    logic [VEC_MAX-1:0] keep_mask;
    logic               in_range, masked_req, req_fire;
    logic               req_send, req_park, req_bad;
    logic               scan_start, scan_active, scan_step, scan_hit;
    logic [VIDX_W-1:0]  scan_idx, fmt_vec;
    msi_msg_t           fmt_msg;
    logic               load_msg;

    // Granted range after clamping the requested count.
    always_comb begin
        log_eff  = clamp_log(cfg_log_vec, LOG_MAX);
        last_idx = VIDX_W'((32'd1 << log_eff) - 32'd1);
    end

    // Keep mask: one bit for each vector inside the granted range.
    for (genvar g = 0; g < VEC_MAX; g++) begin : g_keep
        assign keep_mask[g] = (VIDX_W'(g) <= last_idx);
    end

    // Request classification and walk control.
    always_comb begin
        req_ready  = !msg_valid && !scan_active;
        req_fire   = req_valid && req_ready;
        in_range   = (req_vector <= last_idx);
        masked_req = cfg_mask_cap && cfg_mask[req_vector];
        req_send   = req_fire && cfg_enable && in_range && !masked_req;
        req_park   = req_fire && cfg_enable && in_range && masked_req;
        req_bad    = req_fire && cfg_enable && !in_range;
        scan_start = cfg_update && cfg_enable && cfg_mask_cap;
        scan_step  = scan_active && !msg_valid && !scan_start && cfg_enable;
        scan_hit   = scan_step && pend_vec[scan_idx] && (scan_idx <= last_idx)
                     && !(cfg_mask_cap && cfg_mask[scan_idx]);
        load_msg   = req_send || scan_hit;
        fmt_vec    = scan_hit ? scan_idx : req_vector;
    end

    msi_msg_fmt #(.VIDX_W(VIDX_W)) u_fmt (
        .vec     (fmt_vec),
        .log_n   (log_eff),
        .addr64  (cfg_addr64),
        .addr_lo (cfg_addr_lo),
        .addr_hi (cfg_addr_hi),
        .data16  (cfg_data),
        .msg     (fmt_msg)
    );

    msi_pend_reg #(.VEC_MAX(VEC_MAX)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (req_park),
        .set_idx   (req_vector),
        .clr_en    (scan_hit),
        .clr_idx   (scan_idx),
        .trim_en   (cfg_update && cfg_enable),
        .keep_mask (keep_mask),
        .pend_q    (pend_vec)
    );

    msi_scan_seq #(.VEC_MAX(VEC_MAX)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (scan_start),
        .abort    (!cfg_enable),
        .step_ok  (!msg_valid),
        .last_idx (last_idx),
        .active   (scan_active),
        .idx      (scan_idx)
    );

    // Outgoing message holding register: load on a send, drop on a handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else if (load_msg) begin
            msg_valid <= 1'b1;
            msg_addr  <= fmt_msg.addr;
            msg_data  <= fmt_msg.data;
        end else if (msg_valid && msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    // Error flag: one cycle for an out-of-range request.
    always_ff @(posedge clk) begin
        if (!rst_n) req_err <= 1'b0;
        else        req_err <= req_bad;
    end

    // R1: a masked in-range request produces no message.
    assert_masked_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && cfg_enable && in_range && masked_req) |=> !msg_valid);

    // R8: a held message keeps its contents until taken.
    assert_msg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R9: a request taken while disabled leaves no trace.
    assert_disabled_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && !cfg_enable) |=> (!msg_valid && !req_err && $stable(pend_vec)));

    // R7: an out-of-range request raises the error and sends nothing.
    assert_bad_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && cfg_enable && !in_range) |=> (req_err && !msg_valid));

    // R4: without masking support, no pending bit ever appears.
    assert_no_pend_nocap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mask_cap |=> ((pend_vec & ~$past(pend_vec)) == '0));

    // R5: a configuration write while enabled leaves nothing pending outside the range.
    assert_trim_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_update && cfg_enable) |=> ((pend_vec & ~$past(keep_mask)) == '0));

endmodule

// File: tb/tb_msi_dispatch.sv
module tb_msi_dispatch;

    localparam int CLK_PERIOD = 10;
    localparam int VEC_MAX    = 32;
    localparam int VIDX_W     = $clog2(VEC_MAX);

    logic               clk = 1'b0;
    logic               rst_n;
    logic               req_valid;
    logic [VIDX_W-1:0]  req_vector;
    logic               req_ready, req_err;
    logic               cfg_enable;
    logic [2:0]         cfg_log_vec;
    logic               cfg_addr64;
    logic [31:0]        cfg_addr_lo, cfg_addr_hi;
    logic [15:0]        cfg_data;
    logic               cfg_mask_cap;
    logic [VEC_MAX-1:0] cfg_mask;
    logic               cfg_update;
    logic               msg_valid, msg_ready;
    logic [63:0]        msg_addr;
    logic [31:0]        msg_data;
    logic [VEC_MAX-1:0] pend_vec;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_dispatch #(.VEC_MAX(VEC_MAX)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vector(req_vector),
        .req_ready(req_ready), .req_err(req_err),
        .cfg_enable(cfg_enable), .cfg_log_vec(cfg_log_vec),
        .cfg_addr64(cfg_addr64), .cfg_addr_lo(cfg_addr_lo),
        .cfg_addr_hi(cfg_addr_hi), .cfg_data(cfg_data),
        .cfg_mask_cap(cfg_mask_cap), .cfg_mask(cfg_mask),
        .cfg_update(cfg_update),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data),
        .pend_vec(pend_vec)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Offer one request while the block is idle; return at the following negedge.
    task automatic send_req(input int v);
        @(negedge clk);
        req_valid  = 1'b1;
        req_vector = VIDX_W'(v);
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    // Take the held message and compare it.
    task automatic take_msg(input logic [63:0] ea, input logic [31:0] ed, input string tag);
        chk(msg_valid == 1'b1, {tag, " valid"}, 64'(msg_valid), 64'd1);
        chk(msg_addr == ea, {tag, " addr"}, msg_addr, ea);
        chk(msg_data == ed, {tag, " data"}, 64'(msg_data), 64'(ed));
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic pulse_update();
        @(negedge clk);
        cfg_update = 1'b1;
        @(negedge clk);
        cfg_update = 1'b0;
    endtask

    // Drain messages for a fixed window and record the vector of each one.
    task automatic collect(output int cnt, output int vecs[8], output logic [31:0] dat[8]);
        cnt = 0;
        msg_ready = 1'b1;
        for (int c = 0; c < 80; c++) begin
            if (msg_valid && cnt < 8) begin
                vecs[cnt] = int'(msg_data[2:0]);
                dat[cnt]  = msg_data;
                cnt++;
            end
            @(negedge clk);
        end
        msg_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk(msg_valid == 1'b0, "R11 msg_valid", 64'(msg_valid), 64'd0);
        chk(req_ready == 1'b1, "R11 req_ready", 64'(req_ready), 64'd1);
        chk(req_err == 1'b0, "R11 req_err", 64'(req_err), 64'd0);
        chk(pend_vec == '0, "R11 pend_vec", 64'(pend_vec), 64'd0);
    endtask

    task automatic t_single_32bit();
        cfg_enable = 1; cfg_log_vec = 0; cfg_addr64 = 0;
        cfg_addr_lo = 32'hFEE0_1000; cfg_addr_hi = 32'hDEAD_BEEF; cfg_data = 16'hABCD;
        send_req(0);
        take_msg(64'h0000_0000_FEE0_1000, 32'h0000_ABCD, "R2 R3 single 32-bit");
    endtask

    task automatic t_multi_64bit_stall();
        cfg_log_vec = 3; cfg_addr64 = 1; cfg_data = 16'h1234;
        cfg_addr_lo = 32'hFEE0_2000; cfg_addr_hi = 32'h0000_0001;
        send_req(5);
        for (int k = 0; k < 3; k++) begin
            chk(req_ready == 1'b0, "R8 ready low while held", 64'(req_ready), 64'd0);
            chk(msg_data == 32'h0000_1235, "R8 data stable", 64'(msg_data), 64'h1235);
            @(negedge clk);
        end
        take_msg(64'h0000_0001_FEE0_2000, 32'h0000_1235, "R2 R3 64-bit vector 5");
        chk(req_ready == 1'b1, "R8 ready back", 64'(req_ready), 64'd1);
    endtask

    task automatic t_out_of_range();
        cfg_log_vec = 2; cfg_addr64 = 0;
        send_req(6);
        chk(req_err == 1'b1, "R7 err pulse", 64'(req_err), 64'd1);
        chk(msg_valid == 1'b0, "R7 no message", 64'(msg_valid), 64'd0);
        @(negedge clk);
        chk(req_err == 1'b0, "R7 err one cycle", 64'(req_err), 64'd0);
        chk(pend_vec == '0, "R7 pend untouched", 64'(pend_vec), 64'd0);
    endtask

    task automatic t_clamp();
        cfg_log_vec = 7; cfg_data = 16'h0000;
        send_req(31);
        chk(req_err == 1'b0, "R10 no err at 31", 64'(req_err), 64'd0);
        take_msg(64'h0000_0000_FEE0_2000, 32'h0000_001F, "R10 clamped count 32");
    endtask

    task automatic t_disabled();
        cfg_enable = 0; cfg_log_vec = 3; cfg_mask_cap = 1; cfg_mask = '1;
        send_req(2);
        chk(msg_valid == 1'b0, "R9 no message", 64'(msg_valid), 64'd0);
        chk(pend_vec == '0, "R9 no pending", 64'(pend_vec), 64'd0);
        chk(req_err == 1'b0, "R9 no err", 64'(req_err), 64'd0);
        cfg_enable = 1;
    endtask

    task automatic t_park_and_replay();
        int cnt; int vecs[8]; logic [31:0] dat[8];
        cfg_log_vec = 3; cfg_mask_cap = 1; cfg_data = 16'h5550;
        cfg_mask = 32'h0000_004A;
        send_req(6); send_req(1); send_req(3); send_req(3);
        chk(msg_valid == 1'b0, "R1 masked no message", 64'(msg_valid), 64'd0);
        chk(pend_vec == 32'h4A, "R1 pending bits", 64'(pend_vec), 64'h4A);
        cfg_mask = 32'h0000_0008;
        pulse_update();
        chk(req_ready == 1'b0, "R8 ready low in walk", 64'(req_ready), 64'd0);
        collect(cnt, vecs, dat);
        chk(cnt == 2, "R6 replay count", 64'(cnt), 64'd2);
        chk(vecs[0] == 1, "R6 first replay", 64'(vecs[0]), 64'd1);
        chk(vecs[1] == 6, "R6 second replay", 64'(vecs[1]), 64'd6);
        chk(dat[1] == 32'h5556, "R2 R6 replay data", 64'(dat[1]), 64'h5556);
        chk(pend_vec == 32'h08, "R6 masked stays pending", 64'(pend_vec), 64'h08);
    endtask

    task automatic t_trim();
        int cnt; int vecs[8]; logic [31:0] dat[8];
        cfg_mask = '1;
        send_req(0);
        chk(pend_vec == 32'h09, "R1 pending adds 0", 64'(pend_vec), 64'h09);
        cfg_log_vec = 1;
        pulse_update();
        collect(cnt, vecs, dat);
        chk(cnt == 0, "R5 no messages while masked", 64'(cnt), 64'd0);
        chk(pend_vec == 32'h01, "R5 trimmed above range", 64'(pend_vec), 64'h01);
        cfg_enable = 0; cfg_mask = '0;
        pulse_update();
        collect(cnt, vecs, dat);
        chk(cnt == 0, "R9 update while disabled", 64'(cnt), 64'd0);
        chk(pend_vec == 32'h01, "R9 pending kept", 64'(pend_vec), 64'h01);
        cfg_enable = 1;
        pulse_update();
        collect(cnt, vecs, dat);
        chk(cnt == 1 && vecs[0] == 0, "R6 replay vector 0", 64'(cnt), 64'd1);
        chk(pend_vec == '0, "R6 pending cleared", 64'(pend_vec), 64'd0);
    endtask

    task automatic t_no_mask_cap();
        cfg_mask_cap = 0; cfg_mask = '1; cfg_log_vec = 3; cfg_data = 16'h7770;
        send_req(2);
        take_msg(64'h0000_0000_FEE0_2000, 32'h0000_7772, "R4 unmasked without cap");
        chk(pend_vec == '0, "R4 nothing pending", 64'(pend_vec), 64'd0);
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_vector = '0; msg_ready = 0;
        cfg_enable = 0; cfg_log_vec = 0; cfg_addr64 = 0; cfg_addr_lo = '0;
        cfg_addr_hi = '0; cfg_data = '0; cfg_mask_cap = 0; cfg_mask = '0; cfg_update = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_single_32bit();
        t_multi_64bit_stall();
        t_out_of_range();
        t_clamp();
        t_disabled();
        t_park_and_replay();
        t_trim();
        t_no_mask_cap();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule